// File: doc/BRIEF.md
# Subrectangle Tiling Command Generator

This block takes one rectangular copy request and breaks it into tiles small enough for a blit engine whose largest accepted rectangle is bounded in each direction. For every tile it emits a descriptor made of ready-to-use engine command words. These are a destination point word, a size word, a size word rounded up to even, a byte address into the source surface, a destination format word that carries the destination's power-of-two dimensions as log2 fields, and two fixed-point scale words set to unity.

A request is offered on a valid/ready pair and is taken only while the block is idle. Descriptors leave on a second valid/ready pair, one tile per handshake. A single-cycle `done` pulse marks the end of the request. A request whose destination surface is not a power of two in both dimensions produces no descriptors, and `req_reject` pulses instead. A request with an empty extent finishes at once.

Top module: `tile_cmd_gen`

## Requirements
- R1: Each tile is `min(MAX_W, w - x)` wide and `min(MAX_H, h - y)` tall (default limits 1024, both powers of two). The width limit is evaluated again for every tile, so a narrow last column leaves the first column of the next row at full width.
- R2: Tiles are issued row by row: x advances inside a row, and y advances only after the tile that reaches the right edge of the request.
- R3: `d_point` = `((y+dy) << 16) | (x+dx)` and `d_size` = `(tile_h << 16) | tile_w`, each field 16 bits wide, with height in the upper half.
- R4: `d_rsize` packs the tile width and height the same way as `d_size`, each rounded up to the next even value.
- R5: `d_src_addr` = `src_base + (y+sy)*src_pitch + (x+sx)*bpp`, modulo 2^ADDR_W.
- R6: `d_format` = `fmt | log2(dst_w) << 16 | log2(dst_h) << 24`.
- R7: `d_scale_x` and `d_scale_y` both equal 0x00100000, which is unity with 20 fraction bits.
- R8: If `req_dst_w` or `req_dst_h` is not a power of two, the accepted request emits no descriptor and no `done`, and `req_reject` is high for exactly the cycle after acceptance. This check takes priority over the empty-extent rule.
- R9: `req_ready` is high only while no request is in progress. A request offered while tiles are pending is ignored and does not disturb the descriptors in flight.
- R10: `done` is high for exactly the one cycle after the handshake of the last descriptor.
- R11: A valid request with zero width or zero height emits no descriptors, and `done` is high for the cycle after acceptance.
- R12: While `d_valid` is high and `d_ready` is low, every descriptor word holds its value.
- R13: After reset, `req_ready` is 1 and `d_valid`, `done` and `req_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_src_base | input | ADDR_W | Source surface byte base |
| req_src_pitch | input | PITCH_W | Source row pitch in bytes |
| req_bpp | input | BPP_W | Bytes per pixel |
| req_sx | input | COORD_W | Source origin x |
| req_sy | input | COORD_W | Source origin y |
| req_dx | input | COORD_W | Destination origin x |
| req_dy | input | COORD_W | Destination origin y |
| req_w | input | COORD_W | Copy width in pixels |
| req_h | input | COORD_W | Copy height in pixels |
| req_dst_w | input | DIM_W | Destination surface width (power of two) |
| req_dst_h | input | DIM_W | Destination surface height (power of two) |
| req_fmt | input | FMT_W | Destination format code |
| req_reject | output | 1 | Pulse: request refused for non-power-of-two destination |
| d_valid | output | 1 | Descriptor available |
| d_ready | input | 1 | Descriptor consumer ready |
| d_point | output | 32 | Destination point word |
| d_size | output | 32 | Tile size word |
| d_rsize | output | 32 | Tile size rounded up to even |
| d_src_addr | output | ADDR_W | Tile source byte address |
| d_format | output | 32 | Destination format word |
| d_scale_x | output | 32 | Horizontal scale, unity |
| d_scale_y | output | 32 | Vertical scale, unity |
| done | output | 1 | Pulse after the last descriptor |

## Verification
Several corner cases get their own stimulus. The first is a request wider than two limits whose last column is narrow. A design that carried the narrowed width forward would emit a short first tile in the next row. A height one pixel past twice the limit exercises the row step and the end-of-request test, where an off-by-one would drop the final one-line row or repeat a row. Odd tile sizes, including a 1x1 copy onto a 1x1 surface, expose a rounded size word that is not rounded, or a log2 field that is wrong for size one. A stalled descriptor combined with a competing request shows whether the block takes a second request mid-copy or lets its outputs drift. Non-power-of-two and zero-extent requests show whether a bad request leaks descriptors or a spurious `done`.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
   // Fixed-point unity for the engine's scale words (20 fraction bits)
   localparam logic [31:0] SCALE_UNITY = 32'h0010_0000;
   // Width of one half of a packed 16/16 command word
   localparam int HALF_W = 16;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } tcg_state_e;
endpackage

// File: rtl/tcg_pow2_log.sv
module tcg_pow2_log #(
   parameter int DIM_W = 16,
   parameter int LOG_W = 5
) (
   input  logic [DIM_W-1:0] value,
   output logic             is_pow2,
   output logic [LOG_W-1:0] log2_val
);
   always_comb begin
      is_pow2  = (value != '0) && ((value & (value - 1'b1)) == '0);
      log2_val = '0;
      for (int i = 0; i < DIM_W; i++) begin
         if (value[i]) log2_val = LOG_W'(i);
      end
   end
endmodule

// File: rtl/tcg_stepper.sv
module tcg_stepper #(
   parameter int COORD_W = 16,
   parameter int MAX_W   = 1024,
   parameter int MAX_H   = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               adv,
   input  logic [COORD_W-1:0] ext_w,
   input  logic [COORD_W-1:0] ext_h,
   output logic [COORD_W-1:0] pos_x,
   output logic [COORD_W-1:0] pos_y,
   output logic [COORD_W-1:0] tile_w,
   output logic [COORD_W-1:0] tile_h,
   output logic               row_end,
   output logic               last_tile
);
   localparam int SUM_W = COORD_W + 1;
   localparam logic [COORD_W-1:0] LIM_X = COORD_W'(MAX_W);
   localparam logic [COORD_W-1:0] LIM_Y = COORD_W'(MAX_H);

   logic [COORD_W-1:0] rem_x, rem_y;

   assign rem_x  = ext_w - pos_x;
   assign rem_y  = ext_h - pos_y;
   // limit re-evaluated from the parameter for every tile
   assign tile_w = (rem_x > LIM_X) ? LIM_X : rem_x;
   assign tile_h = (rem_y > LIM_Y) ? LIM_Y : rem_y;

   assign row_end   = (SUM_W'(pos_x) + SUM_W'(tile_w)) >= SUM_W'(ext_w);
   assign last_tile = row_end && ((SUM_W'(pos_y) + SUM_W'(tile_h)) >= SUM_W'(ext_h));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_x <= '0;
         pos_y <= '0;
      end else if (load) begin
         pos_x <= '0;
         pos_y <= '0;
      end else if (adv) begin
         if (row_end) begin
            pos_x <= '0;
            pos_y <= pos_y + tile_h;
         end else begin
            pos_x <= pos_x + tile_w;
         end
      end
   end

   // R2: a tile that does not reach the right edge never moves y
   a_r2_row_major: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !row_end) |=> $stable(pos_y));
   // R1: a tile is never empty and never past its limit
   a_r1_tile_limit: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (tile_w != '0 && tile_w <= LIM_X && tile_h != '0 && tile_h <= LIM_Y));
endmodule

// File: rtl/tcg_pack.sv
module tcg_pack
   import tcg_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int ADDR_W  = 32,
   parameter int PITCH_W = 16,
   parameter int BPP_W   = 4,
   parameter int FMT_W   = 8,
   parameter int LOG_W   = 5
) (
   input  logic [COORD_W-1:0] pos_x,
   input  logic [COORD_W-1:0] pos_y,
   input  logic [COORD_W-1:0] tile_w,
   input  logic [COORD_W-1:0] tile_h,
   input  logic [COORD_W-1:0] org_sx,
   input  logic [COORD_W-1:0] org_sy,
   input  logic [COORD_W-1:0] org_dx,
   input  logic [COORD_W-1:0] org_dy,
   input  logic [ADDR_W-1:0]  src_base,
   input  logic [PITCH_W-1:0] src_pitch,
   input  logic [BPP_W-1:0]   bpp,
   input  logic [FMT_W-1:0]   fmt,
   input  logic [LOG_W-1:0]   log_w,
   input  logic [LOG_W-1:0]   log_h,
   output logic [31:0]        point_word,
   output logic [31:0]        size_word,
   output logic [31:0]        rsize_word,
   output logic [ADDR_W-1:0]  addr_word,
   output logic [31:0]        format_word
);
   logic [HALF_W-1:0] dst_x, dst_y, even_w, even_h;
   logic [ADDR_W-1:0] row_a, col_a;

   assign dst_x = HALF_W'(pos_x + org_dx);
   assign dst_y = HALF_W'(pos_y + org_dy);
   assign point_word = {dst_y, dst_x};
   assign size_word  = {HALF_W'(tile_h), HALF_W'(tile_w)};

   assign even_w = HALF_W'(tile_w) + HALF_W'(tile_w[0]);
   assign even_h = HALF_W'(tile_h) + HALF_W'(tile_h[0]);
   assign rsize_word = {even_h, even_w};

   assign row_a = (ADDR_W'(pos_y) + ADDR_W'(org_sy)) * ADDR_W'(src_pitch);
   assign col_a = (ADDR_W'(pos_x) + ADDR_W'(org_sx)) * ADDR_W'(bpp);
   assign addr_word = src_base + row_a + col_a;

   assign format_word = 32'(fmt) | (32'(log_w) << 16) | (32'(log_h) << 24);
endmodule

// File: rtl/tile_cmd_gen.sv
module tile_cmd_gen
   import tcg_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int ADDR_W  = 32,
   parameter int PITCH_W = 16,
   parameter int BPP_W   = 4,
   parameter int DIM_W   = 16,
   parameter int FMT_W   = 8,
   parameter int MAX_W   = 1024,
   parameter int MAX_H   = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_src_base,
   input  logic [PITCH_W-1:0] req_src_pitch,
   input  logic [BPP_W-1:0]   req_bpp,
   input  logic [COORD_W-1:0] req_sx,
   input  logic [COORD_W-1:0] req_sy,
   input  logic [COORD_W-1:0] req_dx,
   input  logic [COORD_W-1:0] req_dy,
   input  logic [COORD_W-1:0] req_w,
   input  logic [COORD_W-1:0] req_h,
   input  logic [DIM_W-1:0]   req_dst_w,
   input  logic [DIM_W-1:0]   req_dst_h,
   input  logic [FMT_W-1:0]   req_fmt,
   output logic               req_reject,
   output logic               d_valid,
   input  logic               d_ready,
   output logic [31:0]        d_point,
   output logic [31:0]        d_size,
   output logic [31:0]        d_rsize,
   output logic [ADDR_W-1:0]  d_src_addr,
   output logic [31:0]        d_format,
   output logic [31:0]        d_scale_x,
   output logic [31:0]        d_scale_y,
   output logic               done
);
   localparam int LOG_W = $clog2(DIM_W) + 1;
   localparam int N_DIM = 2;

   // elaboration-time parameter checks
   if (MAX_W < 1 || (MAX_W & (MAX_W - 1)) != 0) begin : g_bad_max_w
      $error("MAX_W must be a power of two");
   end
   if (MAX_H < 1 || (MAX_H & (MAX_H - 1)) != 0) begin : g_bad_max_h
      $error("MAX_H must be a power of two");
   end
   if (COORD_W > HALF_W || MAX_W >= (1 << COORD_W) || MAX_H >= (1 << COORD_W)) begin : g_bad_coord
      $error("COORD_W must fit a half word and hold the tile limits");
   end
   if (FMT_W > 16 || LOG_W > 8) begin : g_bad_fields
      $error("format code or log2 field too wide for the format word");
   end

   tcg_state_e         state;
   logic [ADDR_W-1:0]  r_base;
   logic [PITCH_W-1:0] r_pitch;
   logic [BPP_W-1:0]   r_bpp;
   logic [COORD_W-1:0] r_sx, r_sy, r_dx, r_dy, r_w, r_h;
   logic [FMT_W-1:0]   r_fmt;
   logic [LOG_W-1:0]   r_log [N_DIM];

   logic [DIM_W-1:0]   dim_in  [N_DIM];
   logic               dim_ok  [N_DIM];
   logic [LOG_W-1:0]   dim_log [N_DIM];

   assign dim_in[0] = req_dst_w;
   assign dim_in[1] = req_dst_h;

   for (genvar g = 0; g < N_DIM; g++) begin : g_dim
      tcg_pow2_log #(.DIM_W(DIM_W), .LOG_W(LOG_W)) u_plog (
         .value(dim_in[g]), .is_pow2(dim_ok[g]), .log2_val(dim_log[g]));
   end

   logic accept, dims_ok, empty_req, start, adv, last_tile, row_end;
   logic [COORD_W-1:0] pos_x, pos_y, tile_w, tile_h;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign dims_ok   = dim_ok[0] && dim_ok[1];
   assign empty_req = (req_w == '0) || (req_h == '0);
   assign start     = accept && dims_ok && !empty_req;
   assign d_valid   = (state == ST_RUN);
   assign adv       = d_valid && d_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         done       <= 1'b0;
         req_reject <= 1'b0;
         r_base     <= '0;
         r_pitch    <= '0;
         r_bpp      <= '0;
         r_sx       <= '0;
         r_sy       <= '0;
         r_dx       <= '0;
         r_dy       <= '0;
         r_w        <= '0;
         r_h        <= '0;
         r_fmt      <= '0;
         r_log[0]   <= '0;
         r_log[1]   <= '0;
      end else begin
         done       <= 1'b0;
         req_reject <= 1'b0;
         if (accept) begin
            r_base   <= req_src_base;
            r_pitch  <= req_src_pitch;
            r_bpp    <= req_bpp;
            r_sx     <= req_sx;
            r_sy     <= req_sy;
            r_dx     <= req_dx;
            r_dy     <= req_dy;
            r_w      <= req_w;
            r_h      <= req_h;
            r_fmt    <= req_fmt;
            r_log[0] <= dim_log[0];
            r_log[1] <= dim_log[1];
            if (!dims_ok)       req_reject <= 1'b1;
            else if (empty_req) done       <= 1'b1;
            else                state      <= ST_RUN;
         end else if (adv && last_tile) begin
            state <= ST_IDLE;
            done  <= 1'b1;
         end
      end
   end

   tcg_stepper #(.COORD_W(COORD_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_step (
      .clk(clk), .rst_n(rst_n), .load(start), .adv(adv),
      .ext_w(r_w), .ext_h(r_h),
      .pos_x(pos_x), .pos_y(pos_y), .tile_w(tile_w), .tile_h(tile_h),
      .row_end(row_end), .last_tile(last_tile));

   tcg_pack #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
              .BPP_W(BPP_W), .FMT_W(FMT_W), .LOG_W(LOG_W)) u_pack (
      .pos_x(pos_x), .pos_y(pos_y), .tile_w(tile_w), .tile_h(tile_h),
      .org_sx(r_sx), .org_sy(r_sy), .org_dx(r_dx), .org_dy(r_dy),
      .src_base(r_base), .src_pitch(r_pitch), .bpp(r_bpp), .fmt(r_fmt),
      .log_w(r_log[0]), .log_h(r_log[1]),
      .point_word(d_point), .size_word(d_size), .rsize_word(d_rsize),
      .addr_word(d_src_addr), .format_word(d_format));

   assign d_scale_x = SCALE_UNITY;
   assign d_scale_y = SCALE_UNITY;

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_ready) |=> (d_valid && $stable(d_point) && $stable(d_size)
                                 && $stable(d_src_addr) && $stable(d_format)));
   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_ready) |=> !req_ready);
   a_r4_even_round: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (!d_rsize[0] && !d_rsize[16] && d_rsize[15:0] >= d_size[15:0]
                   && d_rsize[31:16] >= d_size[31:16]));
   a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> (!d_valid && !done));
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !d_valid);
endmodule

// File: tb/sim_tile_cmd_gen.sv
module sim_tile_cmd_gen;
   localparam int CLK_PERIOD = 10;
   localparam int LIM = 1024;

   typedef struct packed {
      logic [15:0] w, h, sx, sy, dx, dy;
      logic [31:0] base;
      logic [15:0] pitch;
      logic [3:0]  bpp;
      logic [15:0] dw, dh;
      logic [7:0]  fmt;
   } vec_t;

   localparam int NV = 5;
   localparam vec_t VECS [NV] = '{
      '{16'd8,    16'd4,    16'd3, 16'd2, 16'd1, 16'd5, 32'h0000_1000, 16'd64,   4'd4, 16'd16,   16'd8,    8'h0A},
      '{16'd7,    16'd3,    16'd0, 16'd1, 16'd9, 16'd0, 32'h0002_0000, 16'd32,   4'd2, 16'd8,    16'd4,    8'h03},
      '{16'd2500, 16'd5,    16'd4, 16'd0, 16'd2, 16'd2, 32'h0010_0000, 16'd8192, 4'd1, 16'd4096, 16'd8,    8'h01},
      '{16'd1030, 16'd2049, 16'd1, 16'd3, 16'd0, 16'd7, 32'h0400_0000, 16'd4160, 4'd4, 16'd2048, 16'd4096, 8'h05},
      '{16'd1,    16'd1,    16'd6, 16'd6, 16'd0, 16'd0, 32'h0000_0040, 16'd16,   4'd2, 16'd1,    16'd1,    8'h0F}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, d_ready = 1'b0;
   logic req_ready, req_reject, d_valid, done;
   logic [31:0] req_src_base = '0;
   logic [15:0] req_src_pitch = '0;
   logic [3:0]  req_bpp = '0;
   logic [15:0] req_sx = '0, req_sy = '0, req_dx = '0, req_dy = '0, req_w = '0, req_h = '0;
   logic [15:0] req_dst_w = '0, req_dst_h = '0;
   logic [7:0]  req_fmt = '0;
   logic [31:0] d_point, d_size, d_rsize, d_src_addr, d_format, d_scale_x, d_scale_y;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tile_cmd_gen u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_src_base(req_src_base), .req_src_pitch(req_src_pitch), .req_bpp(req_bpp),
      .req_sx(req_sx), .req_sy(req_sy), .req_dx(req_dx), .req_dy(req_dy),
      .req_w(req_w), .req_h(req_h), .req_dst_w(req_dst_w), .req_dst_h(req_dst_h),
      .req_fmt(req_fmt), .req_reject(req_reject), .d_valid(d_valid), .d_ready(d_ready),
      .d_point(d_point), .d_size(d_size), .d_rsize(d_rsize), .d_src_addr(d_src_addr),
      .d_format(d_format), .d_scale_x(d_scale_x), .d_scale_y(d_scale_y), .done(done));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int lg2(input int v);
      int r = 0;
      for (int i = 0; i < 16; i++) if (v[i]) r = i;
      return r;
   endfunction

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic drive(input vec_t v);
      req_src_base = v.base; req_src_pitch = v.pitch; req_bpp = v.bpp;
      req_sx = v.sx; req_sy = v.sy; req_dx = v.dx; req_dy = v.dy;
      req_w = v.w; req_h = v.h; req_dst_w = v.dw; req_dst_h = v.dh; req_fmt = v.fmt;
   endtask

   // offer a request at a negedge; returns at the negedge after acceptance
   task automatic offer(input vec_t v);
      while (!req_ready) @(negedge clk);
      drive(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input bit stall_first);
      int w = v.w, h = v.h;
      bit first = 1;
      vec_t intruder = VECS[0];
      offer(v);
      for (int y = 0; y < h; y += LIM) begin
         int th = min2(LIM, h - y);
         for (int x = 0; x < w; x += LIM) begin
            int tw = min2(LIM, w - x);
            logic [31:0] e_pt, e_sz, e_rs, e_ad, e_fm;
            e_pt = {16'(y + v.dy), 16'(x + v.dx)};
            e_sz = {16'(th), 16'(tw)};
            e_rs = {16'(th + (th % 2)), 16'(tw + (tw % 2))};
            e_ad = v.base + 32'(y + v.sy) * 32'(v.pitch) + 32'(x + v.sx) * 32'(v.bpp);
            e_fm = 32'(v.fmt) | (32'(lg2(v.dw)) << 16) | (32'(lg2(v.dh)) << 24);
            check("R2 d_valid in tile order", 64'(d_valid), 64'd1);
            check("R2 R3 point word", 64'(d_point), 64'(e_pt));
            check("R1 R3 size word", 64'(d_size), 64'(e_sz));
            check("R4 rounded size", 64'(d_rsize), 64'(e_rs));
            check("R5 source address", 64'(d_src_addr), 64'(e_ad));
            check("R6 format word", 64'(d_format), 64'(e_fm));
            check("R7 scale words", {d_scale_x, d_scale_y}, {32'h0010_0000, 32'h0010_0000});
            if (stall_first && first) begin
               intruder.w = 16'd3;
               drive(intruder);
               req_valid = 1'b1;
               check("R9 busy req_ready", 64'(req_ready), 64'd0);
               @(negedge clk);
               @(negedge clk);
               req_valid = 1'b0;
               drive(v);
               check("R12 held point", 64'(d_point), 64'(e_pt));
               check("R12 held address", 64'(d_src_addr), 64'(e_ad));
               check("R9 busy after stall", 64'(req_ready), 64'd0);
            end
            first = 0;
            d_ready = 1'b1;
            @(negedge clk);
            d_ready = 1'b0;
            if (y + th >= h && x + tw >= w) check("R10 done after last", 64'(done), 64'd1);
            else check("R10 no early done", 64'(done), 64'd0);
         end
      end
      @(negedge clk);
      check("R10 done one cycle", 64'(done), 64'd0);
      check("R2 no extra tile", 64'(d_valid), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      check("R13 req_ready", 64'(req_ready), 64'd1);
      check("R13 outputs idle", {61'd0, d_valid, done, req_reject}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) run_vec(VECS[i], i == 2);

      // R8: non-power-of-two width
      begin
         vec_t v = VECS[0];
         v.dw = 16'd48;
         offer(v);
         check("R8 reject pulse", 64'(req_reject), 64'd1);
         check("R8 no descriptor", {62'd0, d_valid, done}, 64'd0);
         @(negedge clk);
         check("R8 reject one cycle", {61'd0, req_reject, d_valid, done}, 64'd0);
      end
      // R8 priority over empty extent, non-power-of-two height
      begin
         vec_t v = VECS[1];
         v.dh = 16'd0; v.w = 16'd0;
         offer(v);
         check("R8 priority reject", {62'd0, req_reject, done}, 64'd2);
         @(negedge clk);
      end
      // R11: zero width, then zero height
      begin
         vec_t v = VECS[0];
         v.w = 16'd0;
         offer(v);
         check("R11 zero width done", {62'd0, done, d_valid}, 64'd2);
         @(negedge clk);
         check("R11 done one cycle", {62'd0, done, d_valid}, 64'd0);
         v = VECS[3];
         v.h = 16'd0;
         offer(v);
         check("R11 zero height done", {61'd0, done, d_valid, req_reject}, 64'd4);
         @(negedge clk);
         check("R11 idle after empty", 64'(req_ready), 64'd1);
      end
      // block still works after the corner cases
      run_vec(VECS[1], 1'b0);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule